// File: doc/BRIEF.md
# Include/Veto Term Matcher with Lookup Tables

This block decides, once per tick, whether each of four independent channels sees its programmed pattern on a set of 176 input terms. The terms are 128 hardware terms and 48 pseudo terms. The pseudo terms are computed elsewhere and arrive as plain inputs. For each term, a channel can require the term to be high, require it to be low, or ignore it. The requirements are not held as separate flag masks. Each channel has one 16-entry by 1-bit lookup table for every group of four consecutive terms. The live 4-bit value of a group addresses its table, and a channel matches when all 44 of its table outputs are 1.

The tables are loaded through a small register-mapped host port. The host first writes an entry index into the programming-address register and sets the program-enable bit. It then writes one 16-bit word to a programming window. That word sets one entry in each of the sixteen tables the window covers, which are four term groups for each of the four channels. Reading a window returns those same sixteen bits at the current entry. When every table holds all ones, a channel ignores every term and matches on every tick. This is the state after reset.

Top module: `term_match_and`

## Requirements
- R1: While reset is asserted, `match` is 0. All table entries reset to 1, so from the first clock edge after reset is released, every channel reports 1 for any term values.
- R2: `match` is registered. The value seen after a clock edge is computed from the terms and table contents present just before that edge.
- R3: The table for global group g (terms 4g to 4g+3 of the vector {ps_terms, hw_terms}, with hardware terms at 0..127) is read at entry index {t[4g+3], t[4g+2], t[4g+1], t[4g]}. Term 4g is the least significant bit of that index.
- R4: Host addresses 16 to 23 are windows over hardware groups 4(a-16) to 4(a-16)+3. Host addresses 48 to 50 are windows over pseudo groups 32+4(a-48) to 32+4(a-48)+3. In a window word, bit 4*k+c belongs to group k of that window, channel c.
- R5: A window write stores all 16 bits of the word at the entry held in the programming-address register. That register is written at host address 8, bits 3:0.
- R6: Window writes change no table while the program-enable bit is 0. That bit is bit 3 of the control register at host address 0.
- R7: Reading a window address returns the 16 stored bits at the current programming-address entry, in the same layout as R4.
- R8: Channel c matches only when every one of its 44 tables outputs 1. A table that is 0 at every entry blocks its channel.
- R9: Reading address 0 returns the enable in bit 3 and zeros elsewhere. Reading address 8 returns the entry index in bits 3:0. Reading any other address returns 0, and writing it changes nothing.
- R10: Programming one channel's bits leaves the other channels' tables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_terms | input | 128 | Hardware terms |
| ps_terms | input | 48 | Pseudo terms |
| host_addr | input | 6 | Host register address |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, combinational on host_addr |
| match | output | 4 | Registered per-channel match result |

## Verification
Some properties are checked on every cycle. Table storage stays frozen while programming is locked, and also when no window address is written. Every channel reports a match on the tick after all of its tables hold ones. A table with no set entry blocks its channel on the next tick. Other behaviour can only be shown by the directed scenarios. These cover the mapping from term values to table entries, the placement of window bits onto groups and channels, the readback layout, the pseudo-term windows, unmapped addresses, and the one-tick registration of the result.

// File: rtl/tm_pkg.sv
package tm_pkg;
    localparam int TM_CH        = 4;
    localparam int TM_HW_TERMS  = 128;
    localparam int TM_PS_TERMS  = 48;
    localparam int TM_GRP_TERMS = 4;
    localparam int TM_ADDR_W    = 6;
    localparam int TM_DATA_W    = 16;
    localparam int TM_CTRL_ADDR = 0;
    localparam int TM_PADDR_ADDR = 8;
    localparam int TM_HW_BASE   = 16;
    localparam int TM_PS_BASE   = 48;
    localparam int TM_EN_BIT    = 3;
endpackage

// File: rtl/tm_host_regs.sv
module tm_host_regs #(
    parameter int AW         = 6,
    parameter int DW         = 16,
    parameter int ENT_W      = 4,
    parameter int WIDX_W     = 4,
    parameter int HW_BASE    = 16,
    parameter int HW_WORDS   = 8,
    parameter int PS_BASE    = 48,
    parameter int PS_WORDS   = 3,
    parameter int CTRL_ADDR  = 0,
    parameter int PADDR_ADDR = 8,
    parameter int EN_BIT     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     host_addr,
    input  logic              host_wr,
    input  logic [DW-1:0]     host_wdata,
    output logic              prog_en,
    output logic [ENT_W-1:0]  prog_addr,
    output logic              win_hit,
    output logic [WIDX_W-1:0] win_idx,
    output logic [DW-1:0]     reg_rdata
);
    // control and entry-index registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_en   <= 1'b0;
            prog_addr <= '0;
        end else if (host_wr) begin
            if (host_addr == AW'(CTRL_ADDR))
                prog_en <= host_wdata[EN_BIT];
            if (host_addr == AW'(PADDR_ADDR))
                prog_addr <= host_wdata[ENT_W-1:0];
        end
    end

    // window decode: hardware windows first, pseudo windows after them
    always_comb begin
        int a;
        a       = int'(host_addr);
        win_hit = 1'b0;
        win_idx = '0;
        if (a >= HW_BASE && a < HW_BASE + HW_WORDS) begin
            win_hit = 1'b1;
            win_idx = WIDX_W'(a - HW_BASE);
        end else if (a >= PS_BASE && a < PS_BASE + PS_WORDS) begin
            win_hit = 1'b1;
            win_idx = WIDX_W'(HW_WORDS + a - PS_BASE);
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (host_addr == AW'(CTRL_ADDR))
            reg_rdata[EN_BIT] = prog_en;
        else if (host_addr == AW'(PADDR_ADDR))
            reg_rdata[ENT_W-1:0] = prog_addr;
    end
endmodule

// File: rtl/tm_lut_bank.sv
module tm_lut_bank #(
    parameter int CH     = 4,
    parameter int GROUPS = 44,
    parameter int GT     = 4,
    parameter int GPW    = 4,
    parameter int DW     = 16,
    parameter int WIDX_W = 4,
    localparam int ENT   = 1 << GT,
    localparam int TERMS = GROUPS * GT
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [TERMS-1:0]          terms,
    input  logic                      wr_en,
    input  logic [WIDX_W-1:0]         win_idx,
    input  logic [GT-1:0]             prog_addr,
    input  logic [DW-1:0]             wdata,
    output logic [CH*GROUPS-1:0]      hit,
    output logic [DW-1:0]             rd_word,
    output logic [CH*GROUPS*ENT-1:0]  lut_flat
);
    for (genvar c = 0; c < CH; c++) begin : g_ch
        for (genvar g = 0; g < GROUPS; g++) begin : g_grp
            localparam int WORD = g / GPW;
            localparam int BIT  = (g % GPW) * CH + c;
            logic [ENT-1:0] tbl;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    tbl <= '1;
                else if (wr_en && win_idx == WIDX_W'(WORD))
                    tbl[prog_addr] <= wdata[BIT];
            end

            assign hit[c*GROUPS + g]                = tbl[terms[g*GT +: GT]];
            assign lut_flat[(c*GROUPS + g)*ENT +: ENT] = tbl;
        end
    end

    // readback at the current entry, same layout as writes
    always_comb begin
        int gi;
        rd_word = '0;
        for (int k = 0; k < GPW; k++) begin
            for (int c = 0; c < CH; c++) begin
                gi = int'(win_idx) * GPW + k;
                if (gi < GROUPS)
                    rd_word[k*CH + c] = lut_flat[(c*GROUPS + gi)*ENT + int'(prog_addr)];
            end
        end
    end
endmodule

// File: rtl/tm_match_reduce.sv
module tm_match_reduce #(
    parameter int CH     = 4,
    parameter int GROUPS = 44
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CH*GROUPS-1:0] hit,
    output logic [CH-1:0]        match
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            match <= '0;
        else
            for (int c = 0; c < CH; c++)
                match[c] <= &hit[c*GROUPS +: GROUPS];
    end
endmodule

// File: rtl/term_match_and.sv
module term_match_and
    import tm_pkg::*;
#(
    parameter int CH       = TM_CH,
    parameter int HW_TERMS = TM_HW_TERMS,
    parameter int PS_TERMS = TM_PS_TERMS,
    parameter int AW       = TM_ADDR_W,
    parameter int DW       = TM_DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HW_TERMS-1:0] hw_terms,
    input  logic [PS_TERMS-1:0] ps_terms,
    input  logic [AW-1:0]       host_addr,
    input  logic                host_wr,
    input  logic [DW-1:0]       host_wdata,
    output logic [DW-1:0]       host_rdata,
    output logic [CH-1:0]       match
);
    localparam int GT       = TM_GRP_TERMS;
    localparam int ENT      = 1 << GT;
    localparam int TERMS    = HW_TERMS + PS_TERMS;
    localparam int GROUPS   = TERMS / GT;
    localparam int GPW      = DW / CH;
    localparam int HW_WORDS = HW_TERMS / (GT * GPW);
    localparam int PS_WORDS = PS_TERMS / (GT * GPW);
    localparam int WORDS    = HW_WORDS + PS_WORDS;
    localparam int WIDX_W   = $clog2(WORDS);

    logic                     prog_en;
    logic [GT-1:0]            prog_addr;
    logic                     win_hit;
    logic [WIDX_W-1:0]        win_idx;
    logic [DW-1:0]            reg_rdata;
    logic [DW-1:0]            rd_word;
    logic [CH*GROUPS-1:0]     hit;
    logic [CH*GROUPS*ENT-1:0] lut_flat;
    logic                     tbl_wr;

    assign tbl_wr = host_wr && win_hit && prog_en;

    tm_host_regs #(
        .AW(AW), .DW(DW), .ENT_W(GT), .WIDX_W(WIDX_W),
        .HW_BASE(TM_HW_BASE), .HW_WORDS(HW_WORDS),
        .PS_BASE(TM_PS_BASE), .PS_WORDS(PS_WORDS),
        .CTRL_ADDR(TM_CTRL_ADDR), .PADDR_ADDR(TM_PADDR_ADDR), .EN_BIT(TM_EN_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
        .prog_en(prog_en), .prog_addr(prog_addr),
        .win_hit(win_hit), .win_idx(win_idx), .reg_rdata(reg_rdata)
    );

    tm_lut_bank #(
        .CH(CH), .GROUPS(GROUPS), .GT(GT), .GPW(GPW), .DW(DW), .WIDX_W(WIDX_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .terms({ps_terms, hw_terms}),
        .wr_en(tbl_wr), .win_idx(win_idx), .prog_addr(prog_addr), .wdata(host_wdata),
        .hit(hit), .rd_word(rd_word), .lut_flat(lut_flat)
    );

    tm_match_reduce #(.CH(CH), .GROUPS(GROUPS)) u_reduce (
        .clk(clk), .rst_n(rst_n), .hit(hit), .match(match)
    );

    assign host_rdata = win_hit ? rd_word : reg_rdata;
endmodule

// File: rtl/tm_checker.sv
module tm_checker #(
    parameter int CH     = 4,
    parameter int GROUPS = 44,
    parameter int ENT    = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [CH-1:0]             match,
    input logic [CH*GROUPS*ENT-1:0]  lut_flat,
    input logic                      prog_en,
    input logic                      host_wr,
    input logic                      win_hit
);
    logic [CH-1:0] dead_tbl;

    always_comb begin
        dead_tbl = '0;
        for (int c = 0; c < CH; c++)
            for (int g = 0; g < GROUPS; g++)
                if (lut_flat[(c*GROUPS + g)*ENT +: ENT] == '0)
                    dead_tbl[c] = 1'b1;
    end

    AST_RESET_MATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> match == '0); // R1

    AST_LOCKED_TABLES_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |=> $stable(lut_flat)); // R6

    AST_NO_WINDOW_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && win_hit) |=> $stable(lut_flat)); // R9

    AST_ALL_ONES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (&lut_flat) |=> match == '1); // R8

    for (genvar c = 0; c < CH; c++) begin : g_dead
        AST_DEAD_TABLE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            dead_tbl[c] |=> !match[c]); // R8
    end
endmodule

bind term_match_and tm_checker #(.CH(CH), .GROUPS(GROUPS), .ENT(ENT)) u_chk (
    .clk(clk), .rst_n(rst_n), .match(match), .lut_flat(lut_flat),
    .prog_en(prog_en), .host_wr(host_wr), .win_hit(win_hit)
);

// File: tb/test_term_match_and.sv
`timescale 1ns/1ps
module test_term_match_and;
    localparam real CLK_P = 8.0;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] hw_terms = '0;
    logic [47:0]  ps_terms = '0;
    logic [5:0]   host_addr = '0;
    logic         host_wr = 1'b0;
    logic [15:0]  host_wdata = '0;
    logic [15:0]  host_rdata;
    logic [3:0]   match;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // independent model of the tables
    logic [15:0] exp_tbl [4][44];
    bit          m_en   = 0;
    logic [3:0]  m_paddr = '0;

    always #(CLK_P/2) clk = ~clk;

    term_match_and i_term_match_and (
        .clk(clk), .rst_n(rst_n), .hw_terms(hw_terms), .ps_terms(ps_terms),
        .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .match(match)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int win_of(input int a);
        if (a >= 16 && a <= 23) return a - 16;
        if (a >= 48 && a <= 50) return 8 + a - 48;
        return -1;
    endfunction

    task automatic host_write(input int a, input logic [15:0] d);
        int w;
        @(negedge clk);
        host_addr = 6'(a); host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        w = win_of(a);
        if (a == 0) m_en = d[3];
        else if (a == 8) m_paddr = d[3:0];
        else if (w >= 0 && m_en)
            for (int k = 0; k < 4; k++)
                for (int c = 0; c < 4; c++)
                    exp_tbl[c][w*4+k][m_paddr] = d[4*k+c];
    endtask

    task automatic host_read(input int a, output logic [15:0] d);
        host_addr = 6'(a);
        #1;
        d = host_rdata;
    endtask

    function automatic logic [15:0] exp_word(input int a);
        logic [15:0] r;
        int w;
        r = '0;
        w = win_of(a);
        if (w >= 0)
            for (int k = 0; k < 4; k++)
                for (int c = 0; c < 4; c++)
                    r[4*k+c] = exp_tbl[c][w*4+k][m_paddr];
        return r;
    endfunction

    function automatic logic [3:0] exp_match(input logic [127:0] h, input logic [47:0] p);
        logic [175:0] t;
        logic [3:0] m;
        t = {p, h};
        m = '1;
        for (int c = 0; c < 4; c++)
            for (int g = 0; g < 44; g++)
                m[c] = m[c] & exp_tbl[c][g][t[4*g +: 4]];
        return m;
    endfunction

    // req codes per term: 0 ignore, 1 must be high, 2 must be low
    function automatic logic entry_bit(input int r3, input int r2, input int r1, input int r0, input int e);
        int r[4];
        logic b;
        r[0] = r0; r[1] = r1; r[2] = r2; r[3] = r3;
        b = 1'b1;
        for (int i = 0; i < 4; i++) begin
            if (r[i] == 1 && !e[i]) b = 1'b0;
            if (r[i] == 2 &&  e[i]) b = 1'b0;
        end
        return b;
    endfunction

    task automatic apply_and_check(input logic [127:0] h, input logic [47:0] p, input string req);
        logic [3:0] prev;
        @(negedge clk);
        prev = match;
        hw_terms = h; ps_terms = p;
        #1;
        check("R2 held before edge", 16'(match), 16'(prev));
        @(negedge clk);
        check(req, 16'(match), 16'(exp_match(h, p)));
    endtask

    task automatic t_reset();
        logic [15:0] d;
        for (int c = 0; c < 4; c++)
            for (int g = 0; g < 44; g++)
                exp_tbl[c][g] = 16'hFFFF;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 match low in reset", 16'(match), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 all-ignore after reset", 16'(match), 16'hF);
        host_read(0, d);  check("R9 ctrl reset", d, 16'h0);
        host_read(16, d); check("R7 reset readback", d, 16'hFFFF);
        apply_and_check({4{32'hDEADBEEF}}, 48'h123456789ABC, "R8 all ones match");
    endtask

    task automatic t_locked();
        logic [15:0] d;
        host_write(8, 16'h5);
        host_write(16, 16'h0000);
        host_read(16, d); check("R6 locked write ignored", d, 16'hFFFF);
        apply_and_check(128'h5, '0, "R6 locked match unchanged");
    endtask

    task automatic t_program_hw();
        logic [15:0] d;
        host_write(0, 16'h0008);
        host_read(0, d); check("R9 ctrl readback", d, 16'h0008);
        for (int e = 0; e < 16; e++) begin
            logic [15:0] w;
            w = 16'hFFF0;
            w[0] = entry_bit(1, 1, 1, 1, e);
            w[1] = entry_bit(2, 2, 2, 2, e);
            w[2] = entry_bit(0, 0, 0, 0, e);
            w[3] = entry_bit(1, 2, 0, 1, e);
            host_write(8, 16'(e));
            host_write(16, w);
        end
        host_write(8, 16'd9);
        host_read(8, d);  check("R9 paddr readback", d, 16'h0009);
        host_read(16, d); check("R7 entry 9 readback", d, 16'hFFFC);
        host_write(8, 16'd15);
        host_read(16, d); check("R5 entry 15 readback", d, 16'hFFF5);
        host_read(17, d); check("R10 other window untouched", d, 16'hFFFF);
        apply_and_check(128'hF, '0, "R3 nibble F");
        check("R3 nibble F value", 16'(match), 16'h5);
        apply_and_check(128'h0, '0, "R3 nibble 0");
        check("R3 nibble 0 value", 16'(match), 16'h6);
        apply_and_check(128'h9, '0, "R3 nibble 9");
        check("R3 nibble 9 value", 16'(match), 16'hC);
        apply_and_check(128'hB0, '0, "R10 other group ignored");
    endtask

    task automatic t_pseudo();
        logic [15:0] d;
        host_write(8, 16'd0);
        host_write(50, 16'hBFFF);
        host_read(50, d); check("R4 pseudo readback", d, 16'hBFFF);
        apply_and_check(128'h9, 48'h0, "R4 pseudo group blocks ch2");
        check("R4 ch2 blocked value", 16'(match), 16'h8);
        apply_and_check(128'h9, 48'h1000_0000_0000, "R5 other entry passes");
        check("R5 ch2 passes value", 16'(match), 16'hC);
    endtask

    task automatic t_unmapped();
        logic [15:0] d;
        host_write(30, 16'h0000);
        host_read(30, d); check("R9 unmapped reads 0", d, 16'h0);
        host_read(16, d); check("R9 unmapped write no effect", d, exp_word(16));
        apply_and_check(128'h0, 48'h0, "R9 match after unmapped");
    endtask

    task automatic t_relock();
        logic [15:0] d;
        host_write(0, 16'h0000);
        host_write(8, 16'd15);
        host_write(16, 16'h0000);
        host_read(16, d); check("R6 relocked readback", d, 16'hFFF5);
        apply_and_check(128'hF, '0, "R6 relocked match");
    endtask

    initial begin
        t_reset();
        t_locked();
        t_program_hw();
        t_pseudo();
        t_unmapped();
        t_relock();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule